// File: doc/BRIEF.md
# Serial Symmetric FIR Filter

This block is a 9-tap (8th-order) low-pass FIR filter. It uses a single pre-adder and a single multiplier, shared over several clock cycles, in place of one multiplier per tap. Unsigned 4-bit samples arrive on a valid strobe. The block accepts at most one sample every 9 system clocks, so the sample rate is the clock rate divided by 9. Accepted samples go into a 9-stage delay line.

The coefficient set is fixed and symmetric about the centre tap. The datapath therefore first adds each pair of mirrored samples. It multiplies each pair sum, and then the lone centre sample, by the coefficient that pair shares, and adds the product into an accumulator. This takes five steps. After the fifth step the block registers the 10-bit result and raises an output-valid pulse for one cycle. An output is produced in every 9-cycle period, whether or not a new sample came in during that period.

Top module: `serial_sym_fir`

## Requirements
- R1: Each output equals the sum over k=0..8 of c[k]·x[n-k], where x[n] is the newest accepted sample. The coefficients are c = {2,3,6,10,12,10,6,3,2}, and all arithmetic is unsigned.
- R2: A free-running cycle counter runs from 0 to 8. `in_ready_o` is high only while the counter is 0, which is exactly one cycle in every 9. A sample is accepted at the clock edge that ends a cycle in which both `in_valid_i` and `in_ready_o` are high.
- R3: Any `in_valid_i` pulse given while `in_ready_o` is low is ignored, and the delay line keeps its contents.
- R4: `out_valid_o` is high for exactly one cycle per 9-cycle period. That cycle is the 6th cycle after the cycle in which `in_ready_o` was high. `out_data_o` holds its value until the next pulse.
- R5: Input samples are 4 bits wide, and the output is 10 bits wide. With all taps at 15 the output is 810, with no overflow and no saturation.
- R6: While `rst_ni` is low, every delay-line stage and the accumulator are cleared to zero. `out_data_o` and `out_valid_o` are also 0, and `in_ready_o` is 1 because the counter restarts at 0. This applies whether reset is applied at start-up or in the middle of operation.
- R7: A period with no accepted sample still produces an output pulse. That output is computed over the unchanged delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 4 | Unsigned input sample |
| in_ready_o | output | 1 | High in the one cycle of each period when a sample may be accepted |
| out_data_o | output | 10 | Filtered result |
| out_valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions check four things on every cycle:
- the accept window opens once per period;
- the result strobe is a single cycle and comes six cycles after the window;
- a sample lands in the first tap, and the delay line stays frozen at all other times;
- the accumulator never carries out of its 10 bits.

Only the bench scenarios can show that the numeric results match a direct 9-tap convolution. These scenarios cover:
- the impulse response;
- a full-scale step up to 810;
- arbitrary sequences;
- periods with no new sample;
- strobes outside the window;
- a reset given in the middle of a run.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  localparam int unsigned SFIR_ORDER  = 8;
  localparam int unsigned SFIR_DATA_W = 4;
  localparam int unsigned SFIR_COEF_W = 4;
  localparam int unsigned SFIR_OUT_W  = 10;

  // coefficient shared by tap k and tap ORDER-k (k counts from the outer pair)
  function automatic logic [SFIR_COEF_W-1:0] pair_coef(input int unsigned k);
    case (k)
      0:       pair_coef = SFIR_COEF_W'(2);
      1:       pair_coef = SFIR_COEF_W'(3);
      2:       pair_coef = SFIR_COEF_W'(6);
      3:       pair_coef = SFIR_COEF_W'(10);
      4:       pair_coef = SFIR_COEF_W'(12);
      default: pair_coef = '0;
    endcase
  endfunction
endpackage

// File: rtl/sfir_sequencer.sv
module sfir_sequencer #(
  parameter int unsigned NTAP  = 9,
  parameter int unsigned NSTEP = 5,
  localparam int unsigned CNT_W = $clog2(NTAP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             in_ready_o,
  output logic             step_en_o,
  output logic             last_o,
  output logic [CNT_W-1:0] step_idx_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (cnt_q == CNT_W'(NTAP - 1)) cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign in_ready_o = (cnt_q == '0);
  assign step_en_o  = (cnt_q != '0) && (cnt_q <= CNT_W'(NSTEP));
  assign last_o     = (cnt_q == CNT_W'(NSTEP));
  assign step_idx_o = cnt_q - 1'b1;

  a_r2_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o);
  a_r2_ready_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(NTAP - 1)) |=> in_ready_o);
endmodule

// File: rtl/sfir_delay_line.sv
module sfir_delay_line #(
  parameter int unsigned NTAP   = 9,
  parameter int unsigned DATA_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        shift_i,
  input  logic [DATA_W-1:0]           din_i,
  output logic [NTAP-1:0][DATA_W-1:0] taps_o
);
  for (genvar g = 0; g < NTAP; g++) begin : g_stage
    logic [DATA_W-1:0] d;
    if (g == 0) begin : g_head
      assign d = din_i;
    end else begin : g_body
      assign d = taps_o[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      taps_o[g] <= '0;
      else if (shift_i) taps_o[g] <= d;
    end
  end

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(taps_o));
  a_r1_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (taps_o[0] == $past(din_i)));
endmodule

// File: rtl/sfir_mac.sv
module sfir_mac
  import sfir_pkg::*;
#(
  parameter int unsigned NTAP   = 9,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned COEF_W = 4,
  parameter int unsigned OUT_W  = 10,
  localparam int unsigned CNT_W  = $clog2(NTAP),
  localparam int unsigned CENTER = (NTAP - 1) / 2,
  localparam int unsigned SUM_W  = DATA_W + 1,
  localparam int unsigned PROD_W = SUM_W + COEF_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NTAP-1:0][DATA_W-1:0] taps_i,
  input  logic                        step_en_i,
  input  logic                        last_i,
  input  logic [CNT_W-1:0]            step_idx_i,
  output logic [OUT_W-1:0]            out_data_o,
  output logic                        out_valid_o
);
  logic [DATA_W-1:0] near_x, far_x;
  logic [SUM_W-1:0]  pair_sum;
  logic [COEF_W-1:0] coef;
  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  acc_q;
  logic [OUT_W:0]    acc_sum;

  always_comb begin
    near_x = '0;
    far_x  = '0;
    for (int unsigned k = 0; k <= CENTER; k++) begin
      if (step_idx_i == CNT_W'(k)) begin
        near_x = taps_i[k];
        if (k != CENTER) far_x = taps_i[NTAP-1-k];
      end
    end
  end

  // pre-add mirrored pair, then one shared multiply
  assign pair_sum = {1'b0, near_x} + {1'b0, far_x};
  assign coef     = COEF_W'(pair_coef(32'(step_idx_i)));
  assign prod     = PROD_W'(pair_sum) * PROD_W'(coef);
  assign acc_sum  = (OUT_W+1)'(acc_q) + (OUT_W+1)'(prod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      out_data_o  <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      if (step_en_i) begin
        if (last_i) begin
          out_data_o  <= acc_sum[OUT_W-1:0];
          out_valid_o <= 1'b1;
          acc_q       <= '0;
        end else begin
          acc_q <= acc_sum[OUT_W-1:0];
        end
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i |-> !acc_sum[OUT_W]);
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
endmodule

// File: rtl/serial_sym_fir.sv
module serial_sym_fir
  import sfir_pkg::*;
#(
  parameter int unsigned ORDER  = SFIR_ORDER,
  parameter int unsigned DATA_W = SFIR_DATA_W,
  parameter int unsigned COEF_W = SFIR_COEF_W,
  parameter int unsigned OUT_W  = SFIR_OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              out_valid_o
);
  localparam int unsigned NTAP  = ORDER + 1;
  localparam int unsigned NSTEP = ORDER / 2 + 1;
  localparam int unsigned CNT_W = $clog2(NTAP);

  logic                        step_en, last;
  logic [CNT_W-1:0]            step_idx;
  logic [NTAP-1:0][DATA_W-1:0] taps;
  logic                        shift;

  assign shift = in_valid_i & in_ready_o;

  sfir_sequencer #(.NTAP(NTAP), .NSTEP(NSTEP)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_ready_o (in_ready_o),
    .step_en_o  (step_en),
    .last_o     (last),
    .step_idx_o (step_idx)
  );

  sfir_delay_line #(.NTAP(NTAP), .DATA_W(DATA_W)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .din_i   (in_data_i),
    .taps_o  (taps)
  );

  sfir_mac #(.NTAP(NTAP), .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_mac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .taps_i      (taps),
    .step_en_i   (step_en),
    .last_i      (last),
    .step_idx_i  (step_idx),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o)
  );

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_ready_o, NSTEP + 1));
  a_r3_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> $stable(taps));
endmodule

// File: tb/sim_serial_sym_fir.sv
module sim_serial_sym_fir;
  localparam time CLK_PERIOD = 10ns;
  localparam int NT = 9;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [3:0] in_data_i = '0;
  logic       in_ready_o;
  logic [9:0] out_data_o;
  logic       out_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int hist [NT];
  int cf [NT] = '{2, 3, 6, 10, 12, 10, 6, 3, 2};

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_sym_fir u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .out_data_o(out_data_o), .out_valid_o(out_valid_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_out();
    int s = 0;
    for (int k = 0; k < NT; k++) s += cf[k] * hist[k];
    return s;
  endfunction

  task automatic clear_model();
    for (int k = 0; k < NT; k++) hist[k] = 0;
  endtask

  // one sample period; v: offer sample; stray: strobe outside the window
  task automatic run_period(input bit v, input int d, input bit stray);
    int lat;
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = v;
    in_data_i  = 4'(d);
    @(negedge clk_i);
    if (v) begin
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
    end
    in_valid_i = stray;
    in_data_i  = 4'(~d);
    check("R2 ready low after window", int'(in_ready_o), 0);
    lat = 1;
    while (!out_valid_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    in_valid_i = 1'b0;
    check("R4 latency", lat, 6);
    check(v ? "R1 output" : "R7 idle output", int'(out_data_o), ref_out());
    @(negedge clk_i);
    check("R4 single pulse", int'(out_valid_o), 0);
  endtask

  task automatic t_reset();
    check("R6 reset out_data", int'(out_data_o), 0);
    check("R6 reset out_valid", int'(out_valid_o), 0);
    check("R6 reset in_ready", int'(in_ready_o), 1);
  endtask

  task automatic t_impulse();
    run_period(1, 1, 0);
    for (int i = 0; i < NT; i++) run_period(1, 0, 0);
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < NT; i++) run_period(1, 15, 0);
    check("R5 full scale 810", int'(out_data_o), 810);
  endtask

  task automatic t_pattern();
    int seq [12] = '{3, 7, 0, 15, 1, 9, 12, 4, 8, 2, 14, 5};
    foreach (seq[i]) run_period(1, seq[i], 0);
  endtask

  task automatic t_stray();
    run_period(1, 11, 1);
    run_period(0, 6, 1);   // R3: strobes outside window must not move the line
    run_period(1, 13, 1);
  endtask

  task automatic t_idle();
    run_period(0, 9, 0);
    run_period(0, 9, 0);
  endtask

  task automatic t_ready_spacing();
    int hi = 0;
    for (int i = 0; i < 27; i++) begin
      @(negedge clk_i);
      hi += int'(in_ready_o);
    end
    check("R2 ready once per 9", hi, 3);
  endtask

  task automatic t_mid_reset();
    run_period(1, 10, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    clear_model();
    run_period(0, 0, 0);
    check("R6 cleared line", int'(out_data_o), 0);
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_ready_spacing();
    t_impulse();
    t_full_scale();
    t_pattern();
    t_stray();
    t_idle();
    t_mid_reset();
    t_pattern();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule